// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block accepts one stream of RGB pixels at the pixel clock and lays it out on one or two output ports. In single-port arrangement every accepted pixel is placed on port A and port B is released, which is signalled by dropping its output-enable. In the two dual-port arrangements successive pixels are split between the ports: either they land alternately on A and B on successive strobes, or they are gathered into pairs that are shown on both ports at once on every second strobe.

A line-start pulse (the leading edge of Hsync) restarts the odd/even numbering of pixels and is the only moment at which the three mode inputs are taken in. A phase input chooses whether the first pixel of a line goes to port A or port B. A data strobe, one cycle wide, marks each cycle in which new port data has just been presented. Pixels reach the ports one clock after they are accepted.

Top module: `pix_demux`

## Requirements
- R1: After reset port A and port B read 0, the strobe is low, port B's output-enable is high, and the active arrangement is paired dual-port with the first pixel on port A, numbering starting at pixel 1 (odd).
- R2: With demux at 0, each pixel accepted with valid high appears on port A one clock later with the strobe high, port B holds its value and port B's output-enable is low.
- R3: With demux at 0, the parallel input has no effect on the ports, the strobe or the output-enable.
- R4: With demux at 1 and parallel at 0, each accepted pixel appears one clock later on exactly one port with the strobe high; odd pixels go to the first port, even pixels to the other, and the port not written holds its value.
- R5: With demux at 1 and parallel at 1, an odd pixel produces no strobe and no port change; the following even pixel causes both ports to update together one clock later, the first port showing the odd pixel and the other port the even pixel, with the strobe high.
- R6: The phase input at 1 makes port A the first port; at 0 port B is the first port.
- R7: A rising edge on Hsync makes the next accepted pixel pixel 1 (odd); an odd pixel left without a partner at that edge is dropped without a strobe.
- R8: The demux, parallel and phase inputs are taken in only on an Hsync rising edge; changing them at any other time has no effect until the next rising edge.
- R9: The strobe is high only in the cycle after a pixel is accepted; with valid low the ports hold and the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Line sync; rising edge restarts numbering and loads modes |
| pix_vld | input | 1 | Pixel on pix_in is accepted this cycle |
| pix_in | input | 24 | RGB pixel |
| dmx_en | input | 1 | 1: dual-port arrangement, 0: single port A |
| par_en | input | 1 | 1: paired simultaneous, 0: interleaved (dual-port only) |
| a_first | input | 1 | 1: first pixel of a line on port A, 0: on port B |
| port_a | output | 24 | Port A pixel data |
| port_b | output | 24 | Port B pixel data |
| port_b_oe | output | 1 | Port B output-enable, low stands for high impedance |
| dck_en | output | 1 | One-cycle strobe marking freshly presented port data |

## Verification
The assertions watch on every cycle that the strobe only follows an accepted pixel, that the first pixel of a pair never raises it, that an interleaved strobe leaves at least one port untouched, that port B holds in single-port arrangement, and that the latched modes never move between Hsync edges. Which pixel lands on which port, the pairing order under each phase, the dropping of an unpaired pixel at a line edge, and the insensitivity to parallel and to mode changes mid-line can only be shown by the bench's scenarios, which compare full port contents against an independent model.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;

  typedef struct packed {
    logic demux;    // 1: use both ports
    logic pair;     // 1: paired simultaneous, 0: interleaved
    logic a_first;  // 1: first pixel of a line on port A
  } mode_t;

  localparam mode_t MODE_RST = '{demux: 1'b1, pair: 1'b1, a_first: 1'b1};

  typedef enum logic [1:0] {
    ARR_SINGLE = 2'd0,
    ARR_ILV    = 2'd1,
    ARR_PAIR   = 2'd2
  } arr_e;

  function automatic arr_e arrangement(mode_t m);
    if (!m.demux) return ARR_SINGLE;
    return m.pair ? ARR_PAIR : ARR_ILV;
  endfunction

  // Port A receives the pixel when its parity matches the phase choice.
  function automatic logic lands_on_a(logic odd, logic a_first);
    return ~(odd ^ a_first);
  endfunction

endpackage

// File: rtl/pix_demux_linectl.sv
module pix_demux_linectl
  import pix_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hsync,
  input  logic  pix_vld,
  input  mode_t mode_in,
  output logic  hs_rise,
  output mode_t mode_eff,
  output logic  odd_now
);

  logic  hs_d;
  mode_t mode_q;
  logic  odd_q;

  assign hs_rise  = hsync & ~hs_d;
  assign mode_eff = hs_rise ? mode_in : mode_q;
  assign odd_now  = hs_rise ? 1'b1 : odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d   <= 1'b0;
      mode_q <= MODE_RST;
      odd_q  <= 1'b1;
    end else begin
      hs_d <= hsync;
      if (hs_rise) begin
        mode_q <= mode_in;
        odd_q  <= ~pix_vld;
      end else if (pix_vld) begin
        odd_q  <= ~odd_q;
      end
    end
  end

  // R8: latched modes move only on a line edge
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_rise |=> $stable(mode_q));

  // R7: an idle line edge leaves numbering at pixel 1
  a_r7_restart_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !pix_vld) |=> odd_q);

endmodule

// File: rtl/pix_demux_steer.sv
module pix_demux_steer
  import pix_demux_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_in,
  input  mode_t            mode_eff,
  input  logic             odd_now,
  output logic [PIX_W-1:0] port_a,
  output logic [PIX_W-1:0] port_b,
  output logic             port_b_oe,
  output logic             dck_en
);

  localparam int NPORT = 2;

  arr_e arr;
  logic lead_a;
  logic acc_single, acc_ilv, acc_pair_lead, acc_pair_close;
  logic [PIX_W-1:0] hold_q;
  logic [NPORT-1:0] wr;
  logic [NPORT-1:0][PIX_W-1:0] wd;

  assign arr            = arrangement(mode_eff);
  assign lead_a         = lands_on_a(odd_now, mode_eff.a_first);
  assign acc_single     = pix_vld && (arr == ARR_SINGLE);
  assign acc_ilv        = pix_vld && (arr == ARR_ILV);
  assign acc_pair_lead  = pix_vld && (arr == ARR_PAIR) && odd_now;
  assign acc_pair_close = pix_vld && (arr == ARR_PAIR) && !odd_now;

  always_comb begin
    wr[0] = acc_single | (acc_ilv & lead_a) | acc_pair_close;
    wr[1] = (acc_ilv & ~lead_a) | acc_pair_close;
    wd[0] = pix_in;
    wd[1] = pix_in;
    if (acc_pair_close) begin
      if (mode_eff.a_first) wd[0] = hold_q;
      else                  wd[1] = hold_q;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PIX_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr[p]) q <= wd[p];
    end
  end

  assign port_a = g_port[0].q;
  assign port_b = g_port[1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      dck_en    <= 1'b0;
      port_b_oe <= MODE_RST.demux;
    end else begin
      if (acc_pair_lead) hold_q <= pix_in;
      dck_en    <= acc_single | acc_ilv | acc_pair_close;
      port_b_oe <= mode_eff.demux;
    end
  end

  // R9: strobe only after an accepted pixel
  a_r9_strobe_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dck_en |-> $past(pix_vld));

  // R5: the first pixel of a pair raises no strobe
  a_r5_lead_silent: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pair_lead |=> !dck_en);

  // R4: an interleaved strobe touches at most one port
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    (dck_en && $past(acc_ilv)) |-> ($stable(port_a) || $stable(port_b)));

  // R2: port B holds in single-port arrangement
  a_r2_b_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_single) |-> $stable(port_b));

endmodule

// File: rtl/pix_demux.sv
module pix_demux
  import pix_demux_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             dmx_en,
  input  logic             par_en,
  input  logic             a_first,
  output logic [PIX_W-1:0] port_a,
  output logic [PIX_W-1:0] port_b,
  output logic             port_b_oe,
  output logic             dck_en
);

  mode_t mode_in, mode_eff;
  logic  hs_rise, odd_now;

  assign mode_in = '{demux: dmx_en, pair: par_en, a_first: a_first};

  pix_demux_linectl u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync    (hsync),
    .pix_vld  (pix_vld),
    .mode_in  (mode_in),
    .hs_rise  (hs_rise),
    .mode_eff (mode_eff),
    .odd_now  (odd_now)
  );

  pix_demux_steer #(.PIX_W(PIX_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_vld   (pix_vld),
    .pix_in    (pix_in),
    .mode_eff  (mode_eff),
    .odd_now   (odd_now),
    .port_a    (port_a),
    .port_b    (port_b),
    .port_b_oe (port_b_oe),
    .dck_en    (dck_en)
  );

  // R7: a line edge always restarts at an odd pixel
  a_r7_edge_odd: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |-> odd_now);

endmodule

// File: tb/pix_demux_tb.sv
module pix_demux_tb;
  localparam int PIX_W = 24;
  localparam int CLK_P = 10;
  localparam int IW    = 2 * PIX_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, pix_vld = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic dmx_en = 1'b1, par_en = 1'b1, a_first = 1'b1;
  logic [PIX_W-1:0] port_a, port_b;
  logic port_b_oe, dck_en;

  int n_chk = 0, n_err = 0;

  // bench model state
  logic m_dmx = 1'b1, m_par = 1'b1, m_af = 1'b1, m_odd = 1'b1;
  logic [PIX_W-1:0] m_a = '0, m_b = '0, m_hold = '0;
  logic [IW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  pix_demux #(.PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .pix_vld(pix_vld), .pix_in(pix_in),
    .dmx_en(dmx_en), .par_en(par_en), .a_first(a_first),
    .port_a(port_a), .port_b(port_b), .port_b_oe(port_b_oe), .dck_en(dck_en)
  );

  task automatic check(string tag, logic [PIX_W-1:0] act, logic [PIX_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected item on every strobe
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && dck_en) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R9 unexpected strobe actual=1 expected=0");
      end else begin
        logic [IW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " port_a"}, port_a, e[IW-1 -: PIX_W]);
        check({t, " port_b"}, port_b, e[PIX_W:1]);
        check({t, " port_b_oe"}, {23'd0, port_b_oe}, {23'd0, e[0]});
      end
    end
  end

  task automatic line_start(logic d, logic p, logic f);
    hsync = 1'b1; dmx_en = d; par_en = p; a_first = f; pix_vld = 1'b0;
    m_dmx = d; m_par = p; m_af = f; m_odd = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(logic [PIX_W-1:0] px, string tag);
    logic ev;
    ev = 1'b0;
    pix_vld = 1'b1; pix_in = px;
    if (!m_dmx) begin
      m_a = px; ev = 1'b1;
    end else if (!m_par) begin
      if (m_odd == m_af) m_a = px; else m_b = px;
      ev = 1'b1;
    end else if (m_odd) begin
      m_hold = px;
    end else begin
      if (m_af) begin m_a = m_hold; m_b = px; end
      else      begin m_b = m_hold; m_a = px; end
      ev = 1'b1;
    end
    m_odd = ~m_odd;
    if (ev) begin
      exp_q.push_back({m_a, m_b, m_dmx});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    pix_vld = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 port_a", port_a, '0);
    check("R1 port_b", port_b, '0);
    check("R1 dck_en", {23'd0, dck_en}, '0);
    check("R1 port_b_oe", {23'd0, port_b_oe}, 24'd1);
    // R1 default paired arrangement, first on A
    send(24'h111111, "R1");
    send(24'h222222, "R1");
    idle(2);

    // R2 single port, parallel on
    line_start(1'b0, 1'b1, 1'b1);
    check("R2 port_b_oe low", {23'd0, port_b_oe}, '0);
    send(24'hA00001, "R2");
    send(24'hA00002, "R2");
    idle(1);
    send(24'hA00003, "R2");
    idle(2);
    // R3 single port, parallel off: same behaviour
    line_start(1'b0, 1'b0, 1'b0);
    send(24'hB00001, "R3");
    send(24'hB00002, "R3");
    idle(2);
    check("R3 port_b held", port_b, 24'h222222);

    // R4 interleaved, phase A first (R6)
    line_start(1'b1, 1'b0, 1'b1);
    send(24'hC00001, "R4");
    send(24'hC00002, "R4");
    idle(2);
    check("R9 no strobe when idle", {23'd0, dck_en}, '0);
    send(24'hC00003, "R4");
    send(24'hC00004, "R4");
    idle(2);
    // R6 interleaved, phase B first
    line_start(1'b1, 1'b0, 1'b0);
    send(24'hD00001, "R6");
    send(24'hD00002, "R6");
    send(24'hD00003, "R6");
    idle(2);

    // R5 paired, phase B first (R6)
    line_start(1'b1, 1'b1, 1'b0);
    send(24'hE00001, "R5");
    send(24'hE00002, "R5");
    send(24'hE00003, "R5");
    idle(3);
    check("R5 lone odd not shown on port_a", port_a, 24'hE00002);
    // R7 unpaired odd dropped at the line edge
    line_start(1'b1, 1'b1, 1'b1);
    send(24'hF00001, "R7");
    send(24'hF00002, "R7");
    idle(2);

    // R8 mode inputs changed mid-line are ignored
    line_start(1'b1, 1'b1, 1'b1);
    send(24'h700001, "R8");
    dmx_en = 1'b0; par_en = 1'b0; a_first = 1'b0;
    idle(2);
    check("R8 port_b_oe unchanged", {23'd0, port_b_oe}, 24'd1);
    send(24'h700002, "R8");
    send(24'h700003, "R8");
    send(24'h700004, "R8");
    idle(3);

    check("R9 queue drained", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule